// File: doc/BRIEF.md
# Down-Counting Interval Timer Bank with APB Access

This block holds a small bank of independent down-counters, two by default, each clocked by the bus clock and programmed over an APB slave port. A channel is armed by writing a start value and then setting its enable bit. It then counts toward zero one step per clock. On each zero it reloads, either from the programmed start value (periodic mode) or with the all-ones value (free-running mode), and latches a pending interrupt.

Software may mask each channel's interrupt, read the live count, and acknowledge a channel by reading its acknowledge register. A shared register area reports the masked and the unmasked pending bits of all channels together, holds an acknowledge-all register, and returns a fixed version word. A channel's pending bit, qualified by its mask, drives that channel's interrupt output.

Top module: `apb_countdown_timer`

## Requirements
- R1: After reset every channel register, the shared status words and `irq_o` are zero, and the version word at 0xAC reads the `VERSION` parameter.
- R2: Channel n sits at base n*0x14 with start value +0x00, live count +0x04, control +0x08, acknowledge +0x0C, masked status +0x10 (bit 0). The shared masked status is at 0xA0, acknowledge-all at 0xA4, unmasked status at 0xA8 (bit n for channel n), version at 0xAC. Any other offset reads zero. `pready` is high for every access, so there are no wait states.
- R3: Control bit 0 enables the channel. A control write that moves bit 0 from 0 to 1 copies the start value into the counter on that write's clock edge. While enabled, a nonzero count falls by one per clock, and the live count register shows the count at each clock.
- R4: With control bit 1 set (periodic), an enabled channel whose count is zero reloads from the start value at the next edge and sets its pending bit at that edge. The repeat period is therefore start value + 1 clocks.
- R5: With control bit 1 clear (free-running), the reload at zero is 0xFFFFFFFF whatever the start value, and the pending bit is set as in R4.
- R6: While bit 0 is clear, the count holds, no pending bit is set, and writing the start value leaves the count unchanged.
- R7: Control bit 2 masks the channel. The masked status bit and `irq_o[n]` equal pending AND NOT mask, while 0xA8 shows the pending bit regardless of the mask.
- R8: Reading a channel's acknowledge register returns zero and clears only that channel's pending bit. Its count and control are left unchanged.
- R9: Reading 0xA4 clears the pending bit of every channel.
- R10: When a zero reload and a clearing read fall on the same edge, the pending bit stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus and counting clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Always high (no wait states) |
| irq_o | output | NUM_CH | Per-channel masked interrupt |

## Verification
A zero reload and an acknowledge can both land on the same clock edge. One sets a channel's pending bit and the other clears it. The bench provokes this by running a periodic channel with a four-clock period and issuing acknowledge-all reads after 0 to 5 idle cycles, so that the clearing edge sweeps through every phase of the period. The unmasked status read that follows is then compared with a prediction from the edge count: the bit must stay set exactly when a reload fell on the clearing edge or on the edge just after it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int CH_STRIDE = 'h14;
    localparam int OFF_LOAD  = 'h00;
    localparam int OFF_CUR   = 'h04;
    localparam int OFF_CTRL  = 'h08;
    localparam int OFF_ACK   = 'h0C;
    localparam int OFF_ISTAT = 'h10;
    localparam int G_ISTAT   = 'hA0;
    localparam int G_ACK     = 'hA4;
    localparam int G_RAW     = 'hA8;
    localparam int G_VER     = 'hAC;
    localparam int CB_EN     = 0;
    localparam int CB_PER    = 1;
    localparam int CB_MSK    = 2;

    typedef enum logic [2:0] {
        FLD_NONE, FLD_LOAD, FLD_CUR, FLD_CTRL, FLD_ACK, FLD_ISTAT
    } ch_fld_e;

    typedef enum logic [2:0] {
        GS_NONE, GS_ISTAT, GS_ACK, GS_RAW, GS_VER
    } glb_sel_e;
endpackage

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_we,
    input  logic             ctl_we,
    input  logic [31:0]      wdata,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] load_o,
    output logic [2:0]       ctrl_o,
    output logic             raw_o
);
    typedef struct packed {
        logic [CNT_W-1:0] load;
        logic [CNT_W-1:0] cnt;
        logic [2:0]       ctrl;
        logic             raw;
    } ch_state_t;

    ch_state_t s_d, s_q;
    logic      wrap;
    logic      en_rise;

    always_comb begin
        s_d     = s_q;
        wrap    = s_q.ctrl[CB_EN] && (s_q.cnt == '0);
        en_rise = ctl_we && wdata[CB_EN] && !s_q.ctrl[CB_EN];
        if (ld_we) begin
            s_d.load = wdata[CNT_W-1:0];
        end
        if (ctl_we) begin
            s_d.ctrl = wdata[2:0];
        end
        if (en_rise) begin
            s_d.cnt = s_q.load;
        end else if (s_q.ctrl[CB_EN]) begin
            if (wrap) begin
                s_d.cnt = s_q.ctrl[CB_PER] ? s_q.load : '1;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
        if (wrap) begin
            s_d.raw = 1'b1;
        end else if (clr) begin
            s_d.raw = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_o  = s_q.cnt;
    assign load_o = s_q.load;
    assign ctrl_o = s_q.ctrl;
    assign raw_o  = s_q.raw;
endmodule

// File: rtl/tmr_apb_decode.sv
module tmr_apb_decode
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 8
) (
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    output logic [NUM_CH-1:0] ch_hit,
    output ch_fld_e           fld,
    output glb_sel_e          gsel,
    output logic [NUM_CH-1:0] ld_we,
    output logic [NUM_CH-1:0] ctl_we,
    output logic [NUM_CH-1:0] ack_rd,
    output logic              gack_rd
);
    logic acc_wr;
    logic acc_rd;

    always_comb begin
        ch_hit = '0;
        fld    = FLD_NONE;
        for (int i = 0; i < NUM_CH; i++) begin
            if (paddr == ADDR_W'(i*CH_STRIDE + OFF_LOAD)) begin
                ch_hit[i] = 1'b1;
                fld       = FLD_LOAD;
            end
            if (paddr == ADDR_W'(i*CH_STRIDE + OFF_CUR)) begin
                ch_hit[i] = 1'b1;
                fld       = FLD_CUR;
            end
            if (paddr == ADDR_W'(i*CH_STRIDE + OFF_CTRL)) begin
                ch_hit[i] = 1'b1;
                fld       = FLD_CTRL;
            end
            if (paddr == ADDR_W'(i*CH_STRIDE + OFF_ACK)) begin
                ch_hit[i] = 1'b1;
                fld       = FLD_ACK;
            end
            if (paddr == ADDR_W'(i*CH_STRIDE + OFF_ISTAT)) begin
                ch_hit[i] = 1'b1;
                fld       = FLD_ISTAT;
            end
        end
    end

    always_comb begin
        gsel = GS_NONE;
        if (paddr == ADDR_W'(G_ISTAT)) gsel = GS_ISTAT;
        if (paddr == ADDR_W'(G_ACK))   gsel = GS_ACK;
        if (paddr == ADDR_W'(G_RAW))   gsel = GS_RAW;
        if (paddr == ADDR_W'(G_VER))   gsel = GS_VER;
    end

    assign acc_wr  = psel && penable && pwrite;
    assign acc_rd  = psel && penable && !pwrite;
    assign ld_we   = ch_hit & {NUM_CH{acc_wr && (fld == FLD_LOAD)}};
    assign ctl_we  = ch_hit & {NUM_CH{acc_wr && (fld == FLD_CTRL)}};
    assign ack_rd  = ch_hit & {NUM_CH{acc_rd && (fld == FLD_ACK)}};
    assign gack_rd = acc_rd && (gsel == GS_ACK);
endmodule

// File: rtl/apb_countdown_timer.sv
module apb_countdown_timer
    import tmr_pkg::*;
#(
    parameter int          NUM_CH  = 2,
    parameter int          CNT_W   = 32,
    parameter int          ADDR_W  = 8,
    parameter logic [31:0] VERSION = 32'h0103_0A2B
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pready,
    output logic [NUM_CH-1:0] irq_o
);
    logic [NUM_CH-1:0]            ch_hit;
    ch_fld_e                      fld;
    glb_sel_e                     gsel;
    logic [NUM_CH-1:0]            ld_we;
    logic [NUM_CH-1:0]            ctl_we;
    logic [NUM_CH-1:0]            ack_rd;
    logic                         gack_rd;
    logic [NUM_CH-1:0]            clr_vec;
    logic [NUM_CH-1:0][CNT_W-1:0] cnt_vec;
    logic [NUM_CH-1:0][CNT_W-1:0] load_vec;
    logic [NUM_CH-1:0][2:0]       ctrl_vec;
    logic [NUM_CH-1:0]            en_vec;
    logic [NUM_CH-1:0]            per_vec;
    logic [NUM_CH-1:0]            msk_vec;
    logic [NUM_CH-1:0]            raw_vec;
    logic [NUM_CH-1:0]            irq_vec;
    logic [31:0]                  rdata;

    tmr_apb_decode #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_dec (
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .ch_hit  (ch_hit),
        .fld     (fld),
        .gsel    (gsel),
        .ld_we   (ld_we),
        .ctl_we  (ctl_we),
        .ack_rd  (ack_rd),
        .gack_rd (gack_rd)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign clr_vec[g] = ack_rd[g] || gack_rd;

        tmr_channel #(
            .CNT_W (CNT_W)
        ) u_ch (
            .clk    (pclk),
            .rst_n  (presetn),
            .ld_we  (ld_we[g]),
            .ctl_we (ctl_we[g]),
            .wdata  (pwdata),
            .clr    (clr_vec[g]),
            .cnt_o  (cnt_vec[g]),
            .load_o (load_vec[g]),
            .ctrl_o (ctrl_vec[g]),
            .raw_o  (raw_vec[g])
        );

        assign en_vec[g]  = ctrl_vec[g][CB_EN];
        assign per_vec[g] = ctrl_vec[g][CB_PER];
        assign msk_vec[g] = ctrl_vec[g][CB_MSK];
        assign irq_vec[g] = raw_vec[g] && !msk_vec[g];
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ch_hit[i]) begin
                case (fld)
                    FLD_LOAD:  rdata = 32'(load_vec[i]);
                    FLD_CUR:   rdata = 32'(cnt_vec[i]);
                    FLD_CTRL:  rdata = 32'(ctrl_vec[i]);
                    FLD_ISTAT: rdata = 32'(irq_vec[i]);
                    default:   rdata = '0;
                endcase
            end
        end
        case (gsel)
            GS_ISTAT: rdata = 32'(irq_vec);
            GS_RAW:   rdata = 32'(raw_vec);
            GS_VER:   rdata = VERSION;
            default:  ;
        endcase
    end

    assign prdata = (psel && !pwrite) ? rdata : '0;
    assign pready = 1'b1;
    assign irq_o  = irq_vec;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 32
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NUM_CH-1:0][CNT_W-1:0] cnt,
    input logic [NUM_CH-1:0][CNT_W-1:0] load,
    input logic [NUM_CH-1:0]            en,
    input logic [NUM_CH-1:0]            per,
    input logic [NUM_CH-1:0]            msk,
    input logic [NUM_CH-1:0]            raw,
    input logic [NUM_CH-1:0]            ctl_we,
    input logic [NUM_CH-1:0]            clr,
    input logic [NUM_CH-1:0]            irq
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (en[g] && !ctl_we[g] && cnt[g] != '0) |=> (cnt[g] == $past(cnt[g]) - 1'b1));

        assert_periodic_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (en[g] && per[g] && !ctl_we[g] && cnt[g] == '0) |=> (cnt[g] == $past(load[g])));

        assert_free_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (en[g] && !per[g] && !ctl_we[g] && cnt[g] == '0) |=> (cnt[g] == '1));

        assert_hold_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!en[g] && !ctl_we[g]) |=> $stable(cnt[g]));

        assert_no_set_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!en[g] && !raw[g]) |=> !raw[g]);

        assert_mask_gates_R7: assert property (@(posedge clk) disable iff (!rst_n)
            msk[g] |-> !irq[g]);

        assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[g] && !(en[g] && cnt[g] == '0)) |=> !raw[g]);

        assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (en[g] && cnt[g] == '0) |=> raw[g]);
    end
endmodule

bind apb_countdown_timer tmr_checker #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W)
) u_chk (
    .clk    (pclk),
    .rst_n  (presetn),
    .cnt    (cnt_vec),
    .load   (load_vec),
    .en     (en_vec),
    .per    (per_vec),
    .msk    (msk_vec),
    .raw    (raw_vec),
    .ctl_we (ctl_we),
    .clr    (clr_vec),
    .irq    (irq_o)
);

// File: tb/apb_countdown_timer_tb.sv
module apb_countdown_timer_tb;
    localparam logic [31:0] VER = 32'h0103_0A2B;

    logic        pclk    = 1'b0;
    logic        presetn = 1'b0;
    logic        psel    = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite  = 1'b0;
    logic [7:0]  paddr   = '0;
    logic [31:0] pwdata  = '0;
    logic [31:0] prdata;
    logic        pready;
    logic [1:0]  irq_o;

    apb_countdown_timer #(
        .NUM_CH  (2),
        .CNT_W   (32),
        .ADDR_W  (8),
        .VERSION (VER)
    ) u_dut (
        .pclk    (pclk),
        .presetn (presetn),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .prdata  (prdata),
        .pready  (pready),
        .irq_o   (irq_o)
    );

    always #4 pclk = ~pclk;

    int cyc = 0;
    always @(posedge pclk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge pclk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, output int done_e);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge pclk);
        penable = 1'b1;
        done_e  = cyc + 1;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d, output int done_e);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge pclk);
        penable = 1'b1;
        d       = prdata;
        done_e  = cyc + 1;
        if (pready !== 1'b1) check("R2 pready", {31'b0, pready}, 32'd1);
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0;
    endtask

    function automatic logic [31:0] exp_cnt(input int l, input bit per, input int k);
        if (k <= l) return 32'(l - k);
        if (per) return 32'(l - (k % (l + 1)));
        return 32'hFFFF_FFFF - 32'(k - l - 1);
    endfunction

    function automatic bit crossing(input int x, input int e);
        return ((x - e) >= 4) && (((x - e) % 4) == 0);
    endfunction

    initial begin
        repeat (100000) @(posedge pclk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] v1;
        int c;
        int e;
        int k;
        idle(3);
        presetn = 1'b1;
        idle(1);

        // R1: reset state
        check("R1 irq", {30'b0, irq_o}, 32'd0);
        for (int ch = 0; ch < 2; ch++) begin
            for (int off = 0; off <= 'h10; off += 4) begin
                rd(8'(ch * 'h14 + off), d, c);
                check("R1 channel reg", d, 32'd0);
            end
        end
        rd(8'hA0, d, c); check("R1 masked status", d, 32'd0);
        rd(8'hA8, d, c); check("R1 raw status", d, 32'd0);
        rd(8'hAC, d, c); check("R1 version", d, VER);

        // R2: unmapped offsets read zero
        rd(8'h28, d, c); check("R2 unmapped 0x28", d, 32'd0);
        rd(8'h50, d, c); check("R2 unmapped 0x50", d, 32'd0);
        rd(8'h9C, d, c); check("R2 unmapped 0x9C", d, 32'd0);
        rd(8'hB0, d, c); check("R2 unmapped 0xB0", d, 32'd0);
        rd(8'hFC, d, c); check("R2 unmapped 0xFC", d, 32'd0);

        // R3/R4: periodic sweep over start values
        for (int l = 0; l <= 6; l++) begin
            wr(8'h08, 32'd0, c);
            rd(8'hA4, d, c);
            wr(8'h00, 32'(l), c);
            wr(8'h08, 32'd3, e);
            for (int s = 0; s < 5; s++) begin
                rd(8'h04, d, c);
                k = c - 1 - e;
                if (k <= l) check("R3 live count", d, exp_cnt(l, 1'b1, k));
                else        check("R4 periodic count", d, exp_cnt(l, 1'b1, k));
                rd(8'hA8, d, c);
                k = c - 1 - e;
                check("R4 pending after wrap", {31'b0, d[0]}, {31'b0, (k >= l + 1)});
            end
        end

        // R5: free-running sweep
        for (int l = 0; l <= 4; l++) begin
            wr(8'h08, 32'd0, c);
            rd(8'hA4, d, c);
            wr(8'h00, 32'(l), c);
            wr(8'h08, 32'd1, e);
            for (int s = 0; s < 5; s++) begin
                rd(8'h04, d, c);
                k = c - 1 - e;
                check("R5 free-running count", d, exp_cnt(l, 1'b0, k));
                rd(8'hA8, d, c);
                k = c - 1 - e;
                check("R5 pending after wrap", {31'b0, d[0]}, {31'b0, (k >= l + 1)});
            end
        end

        // R6: disabled channel holds and stays quiet
        wr(8'h08, 32'd0, c);
        rd(8'hA4, d, c);
        rd(8'h04, v1, c);
        idle(10);
        rd(8'h04, d, c);  check("R6 hold while off", d, v1);
        wr(8'h00, 32'd99, c);
        rd(8'h04, d, c);  check("R6 start write leaves count", d, v1);
        rd(8'hA8, d, c);  check("R6 no pending while off", d, 32'd0);
        check("R6 irq low", {30'b0, irq_o}, 32'd0);

        // R7: mask on channel 1
        wr(8'h1C, 32'd0, c);
        wr(8'h14, 32'd2, c);
        wr(8'h1C, 32'd7, c);
        idle(6);
        rd(8'hA8, d, c);  check("R7 raw shows masked pending", {31'b0, d[1]}, 32'd1);
        rd(8'hA0, d, c);  check("R7 masked status hidden", {31'b0, d[1]}, 32'd0);
        rd(8'h24, d, c);  check("R7 channel status hidden", d, 32'd0);
        check("R7 irq masked", {31'b0, irq_o[1]}, 32'd0);
        wr(8'h1C, 32'd3, c);
        rd(8'h24, d, c);  check("R7 channel status shown", d, 32'd1);
        rd(8'hA0, d, c);  check("R7 masked status shown", {31'b0, d[1]}, 32'd1);
        check("R7 irq unmasked", {31'b0, irq_o[1]}, 32'd1);
        wr(8'h1C, 32'd0, c);
        rd(8'hA4, d, c);

        // R8/R9: acknowledge per channel and for all
        wr(8'h00, 32'd3, c);
        wr(8'h08, 32'd1, e);
        wr(8'h14, 32'd4, c);
        wr(8'h1C, 32'd1, c);
        idle(12);
        check("R8 both pending irq", {30'b0, irq_o}, 32'd3);
        rd(8'h0C, d, c);  check("R8 acknowledge reads zero", d, 32'd0);
        rd(8'hA8, d, c);  check("R8 only channel 0 cleared", d, 32'd2);
        rd(8'h08, d, c);  check("R8 control unchanged", d, 32'd1);
        rd(8'h04, d, c);
        k = c - 1 - e;
        check("R8 count unchanged", d, exp_cnt(3, 1'b0, k));
        rd(8'hA4, d, c);  check("R9 acknowledge-all reads zero", d, 32'd0);
        rd(8'hA8, d, c);  check("R9 all cleared", d, 32'd0);
        check("R9 irq low", {30'b0, irq_o}, 32'd0);
        wr(8'h1C, 32'd0, c);

        // R10: clear and reload on the same edge, every phase
        wr(8'h08, 32'd0, c);
        wr(8'h00, 32'd3, c);
        wr(8'h08, 32'd3, e);
        idle(5);
        for (int ph = 0; ph < 6; ph++) begin
            int cc;
            idle(ph);
            rd(8'hA4, d, cc);
            rd(8'hA8, d, c);
            check("R10 set beats clear", {31'b0, d[0]},
                  {31'b0, (crossing(cc, e) || crossing(cc + 1, e))});
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule